// File: doc/BRIEF.md
# CCD Readout Timing Sequencer

This block produces the digital timing that reads a full-frame CCD out row by row. Each row starts with a three-phase vertical charge transfer in which the third phase fires twice. A horizontal readout follows. It cycles three horizontal phases and a summing-well gate once per pixel. Alongside these phases it places the clamp, sample and start-convert strobes that drive an external correlated double sampler and its converter. The converter's 16-bit result for each pixel is captured and sent out. Each output word carries a valid strobe, a row index, a column index and a flag for overscan positions.

A frame begins on a start pulse. At that moment the block latches the row count, the active column count, the overscan count and the pixel period in 100 MHz cycles. Every row then reads the overscan pixels, the active pixels and the overscan pixels again. The default period of 667 cycles gives about 150 kpixel/s. The shortest allowed period of 20 cycles gives 5 Mpixel/s. After the last pixel of the last row the block pulses frame-done and returns to idle. In idle every phase and strobe output is low.

Top module: `ccd_readout_seq`

## Requirements
- R1: While in reset and when idle, every phase output (v1_o, v2_o, v3_o, h1_o, h2_o, h3_o, sw_o), every strobe (clamp_o, sample_o, conv_o), pix_valid_o and frame_done_o are 0.
- R2: start_i is taken only while idle, and only when rows_i is nonzero and the row width cols_i + 2*ovsc_i is nonzero. When start_i is ignored, no phase moves, no pixel is output and no frame-done occurs. A start during a frame has no effect on that frame.
- R3: Each row begins with a vertical transfer of 8*VSTEP cycles. It has eight steps of VSTEP cycles each, in this order: V1; V1+V2; V2; V2+V3; V3; none; V3; none. V1 therefore pulses once per row and V3 twice. No vertical phase is high while any horizontal phase or CDS strobe is high.
- R4: The pixel period is P = max(pix_period_i, MIN_PER) clock cycles. H1 rises once per pixel. Consecutive pixels of one row are exactly P cycles apart. The last pixel of one row and the first pixel of the next are P + 8*VSTEP cycles apart.
- R5: With Q = P>>2 and c the cycle index within the pixel (c = 0 when H1 rises): clamp_o is high for c < Q; sample_o is high for 2Q <= c < 3Q; conv_o is high only at c = 3Q; H1 is high for c < 2Q, H2 for Q <= c < 3Q, H3 for c >= 2Q, and the summing well for c >= 3Q.
- R6: A row of width W = cols + 2*ovsc yields the column tags 0 to W-1 in order. pix_ovsc_o is 1 when the column is below ovsc or at least ovsc + cols. Rows are tagged 0 to rows-1 in order.
- R7: Each pixel yields exactly one one-cycle pix_valid_o pulse. pix_data_o equals adc_data_i as sampled on the clock edge that ends the pixel's last cycle, and it appears in the cycle after that edge.
- R8: The first pix_valid_o of a frame appears 8*VSTEP + P clock edges after the edge that accepts start_i.
- R9: frame_done_o is a single one-cycle pulse per frame. It coincides with the valid pulse of the last pixel (column W-1, row rows-1). In the following cycle every phase and strobe output is 0.
- R10: The dimensions and the period are latched at the accepted start. Changing rows_i, cols_i, ovsc_i or pix_period_i during a frame does not change that frame's pixel count, tags or spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start request |
| rows_i | input | ROW_W | Number of rows per frame |
| cols_i | input | COL_W | Active pixels per row |
| ovsc_i | input | OVS_W | Overscan pixels on each side of a row |
| pix_period_i | input | PER_W | Pixel period in clock cycles |
| adc_data_i | input | DATA_W | Converter result |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| v3_o | output | 1 | Vertical phase 3 |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| h3_o | output | 1 | Horizontal phase 3 |
| sw_o | output | 1 | Summing-well gate |
| clamp_o | output | 1 | CDS reset-level clamp |
| sample_o | output | 1 | CDS video-level sample |
| conv_o | output | 1 | Converter start strobe |
| pix_valid_o | output | 1 | Pixel word valid |
| pix_data_o | output | DATA_W | Pixel value |
| pix_row_o | output | ROW_W | Row index of the pixel |
| pix_col_o | output | COL_W+1 | Column index within the row, overscan included |
| pix_ovsc_o | output | 1 | Pixel is an overscan position |
| frame_done_o | output | 1 | Last pixel of the frame |

## Verification
Some properties are checked on every cycle. No vertical phase may overlap a horizontal phase or strobe. V1 and V3 may never be high together, and all vertical phases must be low at the end of a transfer. Convert must directly follow sample. The pixel counter must stay inside the period. Valid pulses last one cycle, and every column tag must lie within the row. Frame-done must coincide with a valid pulse and must be followed by idle outputs. Other results can only be seen across whole frames in the bench scenarios: pulse counts per row, exact spacing between pixels and rows, strobe positions for a given period, tag order, overscan flags, data capture, start latency, ignored starts, and immunity to configuration changes during a frame.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_VXFER = 2'd1,
    ST_HREAD = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  // number of steps in one vertical row transfer
  localparam int unsigned V_STEPS = 8;
endpackage

// File: rtl/ccd_vxfer.sv
module ccd_vxfer #(
  parameter int unsigned VSTEP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic v1,
  output logic v2,
  output logic v3,
  output logic done
);
  import ccd_seq_pkg::*;
  localparam int unsigned SUB_W  = (VSTEP > 1) ? $clog2(VSTEP) : 1;
  localparam int unsigned STEP_W = $clog2(V_STEPS);

  logic [STEP_W-1:0] step_q, step_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic              sub_end;

  assign sub_end = (sub_q == SUB_W'(VSTEP - 1));
  assign done    = run && sub_end && (step_q == STEP_W'(V_STEPS - 1));

  always_comb begin
    step_d = step_q;
    sub_d  = sub_q;
    if (!run) begin
      step_d = '0;
      sub_d  = '0;
    end else if (sub_end) begin
      sub_d  = '0;
      step_d = step_q + STEP_W'(1);
    end else begin
      sub_d = sub_q + SUB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      sub_q  <= '0;
    end else begin
      step_q <= step_d;
      sub_q  <= sub_d;
    end
  end

  // step decode: V3 fires in steps 3..4 and again in step 6
  always_comb begin
    {v1, v2, v3} = 3'b000;
    if (run) begin
      case (step_q)
        STEP_W'(0): {v1, v2, v3} = 3'b100;
        STEP_W'(1): {v1, v2, v3} = 3'b110;
        STEP_W'(2): {v1, v2, v3} = 3'b010;
        STEP_W'(3): {v1, v2, v3} = 3'b011;
        STEP_W'(4): {v1, v2, v3} = 3'b001;
        STEP_W'(6): {v1, v2, v3} = 3'b001;
        default:    {v1, v2, v3} = 3'b000;
      endcase
    end
  end

  a_r3_v1_v3_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(v1 && v3));
  a_r3_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(v1 || v2 || v3));
endmodule

// File: rtl/ccd_pixel_gen.sv
module ccd_pixel_gen #(
  parameter int unsigned PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             h1,
  output logic             h2,
  output logic             h3,
  output logic             sw,
  output logic             clamp,
  output logic             sample,
  output logic             conv,
  output logic             last
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] q1, q2, q3;

  assign q1 = period >> 2;
  assign q2 = q1 << 1;
  assign q3 = q2 + q1;
  assign last = run && (cnt_q == period - PER_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || last) cnt_d = '0;
    else              cnt_d = cnt_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign h1     = run && (cnt_q < q2);
  assign h2     = run && (cnt_q >= q1) && (cnt_q < q3);
  assign h3     = run && (cnt_q >= q2);
  assign sw     = run && (cnt_q >= q3);
  assign clamp  = run && (cnt_q < q1);
  assign sample = run && (cnt_q >= q2) && (cnt_q < q3);
  assign conv   = run && (cnt_q == q3);

  a_r5_conv_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    conv |-> $past(sample));
  a_r4_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < period));
endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq #(
  parameter int unsigned ROW_W   = 12,
  parameter int unsigned COL_W   = 12,
  parameter int unsigned OVS_W   = 7,
  parameter int unsigned PER_W   = 12,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned VSTEP   = 8,
  parameter int unsigned MIN_PER = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  rows_i,
  input  logic [COL_W-1:0]  cols_i,
  input  logic [OVS_W-1:0]  ovsc_i,
  input  logic [PER_W-1:0]  pix_period_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              v1_o,
  output logic              v2_o,
  output logic              v3_o,
  output logic              h1_o,
  output logic              h2_o,
  output logic              h3_o,
  output logic              sw_o,
  output logic              clamp_o,
  output logic              sample_o,
  output logic              conv_o,
  output logic              pix_valid_o,
  output logic [DATA_W-1:0] pix_data_o,
  output logic [ROW_W-1:0]  pix_row_o,
  output logic [COL_W:0]    pix_col_o,
  output logic              pix_ovsc_o,
  output logic              frame_done_o
);
  import ccd_seq_pkg::*;
  localparam int unsigned WID_W = COL_W + 1;

  seq_state_e       state_q, state_d;
  logic [ROW_W-1:0] rows_q, rows_d, row_q, row_d;
  logic [COL_W-1:0] cols_q, cols_d;
  logic [OVS_W-1:0] ovsc_q, ovsc_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [WID_W-1:0] width_q, width_d, col_q, col_d, width_in;
  logic             v_run, v_done, p_run, p_last, cap_en, ovsc_flag;

  assign width_in  = WID_W'(cols_i) + (WID_W'(ovsc_i) << 1);
  assign v_run     = (state_q == ST_VXFER);
  assign p_run     = (state_q == ST_HREAD);
  assign cap_en    = p_run && p_last;
  assign ovsc_flag = (col_q < WID_W'(ovsc_q)) ||
                     (col_q >= WID_W'(ovsc_q) + WID_W'(cols_q));

  ccd_vxfer #(.VSTEP(VSTEP)) i_vxfer (
    .clk(clk), .rst_n(rst_n), .run(v_run),
    .v1(v1_o), .v2(v2_o), .v3(v3_o), .done(v_done)
  );

  ccd_pixel_gen #(.PER_W(PER_W)) i_pixel (
    .clk(clk), .rst_n(rst_n), .run(p_run), .period(per_q),
    .h1(h1_o), .h2(h2_o), .h3(h3_o), .sw(sw_o),
    .clamp(clamp_o), .sample(sample_o), .conv(conv_o), .last(p_last)
  );

  always_comb begin
    state_d = state_q;
    rows_d  = rows_q;
    cols_d  = cols_q;
    ovsc_d  = ovsc_q;
    per_d   = per_q;
    width_d = width_q;
    row_d   = row_q;
    col_d   = col_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i && (rows_i != '0) && (width_in != '0)) begin
          state_d = ST_VXFER;
          rows_d  = rows_i;
          cols_d  = cols_i;
          ovsc_d  = ovsc_i;
          width_d = width_in;
          per_d   = (pix_period_i < PER_W'(MIN_PER)) ? PER_W'(MIN_PER) : pix_period_i;
          row_d   = '0;
          col_d   = '0;
        end
      end
      ST_VXFER: if (v_done) state_d = ST_HREAD;
      ST_HREAD: begin
        if (p_last) begin
          if (col_q == width_q - WID_W'(1)) begin
            col_d = '0;
            if (row_q == rows_q - ROW_W'(1)) begin
              state_d = ST_DONE;
            end else begin
              row_d   = row_q + ROW_W'(1);
              state_d = ST_VXFER;
            end
          end else begin
            col_d = col_q + WID_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rows_q  <= '0;
      cols_q  <= '0;
      ovsc_q  <= '0;
      per_q   <= '0;
      width_q <= '0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      state_q <= state_d;
      rows_q  <= rows_d;
      cols_q  <= cols_d;
      ovsc_q  <= ovsc_d;
      per_q   <= per_d;
      width_q <= width_d;
      row_q   <= row_d;
      col_q   <= col_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid_o <= 1'b0;
      pix_data_o  <= '0;
      pix_row_o   <= '0;
      pix_col_o   <= '0;
      pix_ovsc_o  <= 1'b0;
    end else begin
      pix_valid_o <= cap_en;
      if (cap_en) begin
        pix_data_o <= adc_data_i;
        pix_row_o  <= row_q;
        pix_col_o  <= col_q;
        pix_ovsc_o <= ovsc_flag;
      end
    end
  end

  assign frame_done_o = (state_q == ST_DONE);

  a_r3_no_v_during_h: assert property (@(posedge clk) disable iff (!rst_n)
    (h1_o || h2_o || h3_o || sw_o || clamp_o || sample_o || conv_o) |-> !(v1_o || v2_o || v3_o));
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |=> !pix_valid_o);
  a_r6_col_in_row: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> (pix_col_o < width_q));
  a_r9_done_with_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> pix_valid_o);
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !(v1_o || v2_o || v3_o || h1_o || h2_o || h3_o || sw_o ||
                      clamp_o || sample_o || conv_o || frame_done_o));
endmodule

// File: tb/test_ccd_readout_seq.sv
module test_ccd_readout_seq;
  localparam int VST  = 8;
  localparam int MINP = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [11:0] rows_i;
  logic [11:0] cols_i;
  logic [6:0]  ovsc_i;
  logic [11:0] pix_period_i;
  logic [15:0] adc_data_i;
  logic v1_o, v2_o, v3_o, h1_o, h2_o, h3_o, sw_o, clamp_o, sample_o, conv_o;
  logic        pix_valid_o;
  logic [15:0] pix_data_o;
  logic [11:0] pix_row_o;
  logic [12:0] pix_col_o;
  logic        pix_ovsc_o;
  logic        frame_done_o;

  ccd_readout_seq i_ccd_readout_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rows_i(rows_i), .cols_i(cols_i),
    .ovsc_i(ovsc_i), .pix_period_i(pix_period_i), .adc_data_i(adc_data_i),
    .v1_o(v1_o), .v2_o(v2_o), .v3_o(v3_o), .h1_o(h1_o), .h2_o(h2_o), .h3_o(h3_o),
    .sw_o(sw_o), .clamp_o(clamp_o), .sample_o(sample_o), .conv_o(conv_o),
    .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o), .pix_row_o(pix_row_o),
    .pix_col_o(pix_col_o), .pix_ovsc_o(pix_ovsc_o), .frame_done_o(frame_done_o)
  );

  always #5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int pcyc = 0;
  int s_edge = 0;
  int frame_id = 0;
  int m_rows, m_cols, m_ovsc, m_w, m_p;

  // monitor statistics, written only by the monitor
  int seen_id = 0;
  int nvalid, seqerr, daterr, gaperr, first_lat, last_vpc;
  int v1r, v3r, h1r, ovl, cdserr, ndone, doneerr, pos, ecol, erow;
  logic pv1, pv3, ph1, pdone;

  always @(posedge clk) pcyc <= pcyc + 1;

  function automatic int eff_period(int p);
    return (p < MINP) ? MINP : p;
  endfunction

  function automatic logic any_out();
    return v1_o | v2_o | v3_o | h1_o | h2_o | h3_o | sw_o | clamp_o | sample_o | conv_o;
  endfunction

  always @(negedge clk) begin
    int q, gap;
    logic eovs;
    if (seen_id != frame_id) begin
      seen_id = frame_id;
      nvalid = 0; seqerr = 0; daterr = 0; gaperr = 0; first_lat = -1; last_vpc = 0;
      v1r = 0; v3r = 0; h1r = 0; ovl = 0; cdserr = 0; ndone = 0; doneerr = 0;
      pos = 0; ecol = 0; erow = 0; pv1 = 0; pv3 = 0; ph1 = 0; pdone = 0;
    end
    q = m_p >> 2;
    if (pix_valid_o) begin
      nvalid++;
      eovs = (ecol < m_ovsc) || (ecol >= m_ovsc + m_cols);
      if (pix_col_o !== 13'(ecol) || pix_row_o !== 12'(erow) || pix_ovsc_o !== eovs) seqerr++;
      if (pix_data_o !== adc_data_i) daterr++;
      if (nvalid == 1) first_lat = pcyc - s_edge;
      else begin
        gap = (ecol == 0) ? m_p + 8 * VST : m_p;
        if (pcyc - last_vpc != gap) gaperr++;
      end
      last_vpc = pcyc;
      ecol++;
      if (ecol == m_w) begin ecol = 0; erow++; end
    end
    if (v1_o && !pv1) v1r++;
    if (v3_o && !pv3) v3r++;
    if (h1_o && !ph1) begin h1r++; pos = 0; end else pos++;
    if ((v1_o | v2_o | v3_o) && (h1_o | h2_o | h3_o | sw_o | clamp_o | sample_o | conv_o)) ovl++;
    if (h1_o | h2_o | h3_o | sw_o) begin
      if (clamp_o !== (pos < q) || sample_o !== (pos >= 2*q && pos < 3*q) ||
          conv_o !== (pos == 3*q) || h1_o !== (pos < 2*q) ||
          h2_o !== (pos >= q && pos < 3*q) || h3_o !== (pos >= 2*q) || sw_o !== (pos >= 3*q))
        cdserr++;
    end else if (clamp_o | sample_o | conv_o) cdserr++;
    if (frame_done_o) begin
      ndone++;
      if (!(pix_valid_o && pix_col_o == 13'(m_w - 1) && pix_row_o == 12'(m_rows - 1))) doneerr++;
    end
    if (pdone && (any_out() || frame_done_o)) doneerr++;
    pv1 = v1_o; pv3 = v3_o; ph1 = h1_o; pdone = frame_done_o;
    adc_data_i = 16'($urandom);
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic open_frame(int r, int c, int o, int p);
    @(posedge clk); #1;
    frame_id++;
    m_rows = r; m_cols = c; m_ovsc = o; m_w = c + 2*o; m_p = eff_period(p);
    @(negedge clk);
    rows_i = 12'(r); cols_i = 12'(c); ovsc_i = 7'(o); pix_period_i = 12'(p);
    start_i = 1'b1;
    @(posedge clk); #1 s_edge = pcyc;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic run_frame(int r, int c, int o, int p, bit disturb);
    int t = 0;
    open_frame(r, c, o, p);
    while (ndone == 0 && t < 40000) begin
      @(negedge clk);
      t++;
      if (disturb && t == 200) begin
        start_i = 1'b1; rows_i = 12'(r + 2); cols_i = 12'(c + 3);
        ovsc_i = 7'(o + 1); pix_period_i = 12'(p + 7);
      end else if (disturb && t == 201) start_i = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk("R9 frame finished before timeout", (t < 40000) ? 1 : 0, 1);
    chk(disturb ? "R10 R2 pixel count with inputs changed mid-frame" : "R7 pixel count",
        nvalid, r * (c + 2*o));
    chk("R6 row/column tags and overscan flag", seqerr, 0);
    chk("R7 captured data", daterr, 0);
    chk("R3 V1 pulses", v1r, r);
    chk("R3 V3 pulses (two per row)", v3r, 2 * r);
    chk("R3 vertical/horizontal overlap", ovl, 0);
    chk("R4 H1 pulses", h1r, r * (c + 2*o));
    chk(disturb ? "R10 R4 pixel and row spacing" : "R4 pixel and row spacing", gaperr, 0);
    chk("R5 strobe and phase placement", cdserr, 0);
    chk("R8 first pixel latency", first_lat, 8 * VST + m_p);
    chk("R9 done pulse count", ndone, 1);
    chk("R9 done alignment and idle after", doneerr, 0);
    chk("R1 idle outputs after frame", any_out() ? 1 : 0, 0);
  endtask

  task automatic run_ignored(int r, int c, int o);
    open_frame(r, c, o, 30);
    repeat (300) @(negedge clk);
    chk("R2 ignored start: no pixels", nvalid, 0);
    chk("R2 ignored start: no done", ndone, 0);
    chk("R2 ignored start: no vertical pulse", v1r + h1r, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk + 1, nerr + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; rows_i = '0; cols_i = '0; ovsc_i = '0;
    pix_period_i = '0; adc_data_i = '0;
    m_rows = 1; m_cols = 1; m_ovsc = 0; m_w = 1; m_p = MINP;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {any_out(), pix_valid_o, frame_done_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 outputs idle after reset", {any_out(), pix_valid_o, frame_done_o}, 0);

    run_frame(1, 1, 0, 5, 1'b0);      // period below minimum, smallest frame
    run_frame(2, 4, 2, 20, 1'b0);     // shortest period with overscan
    run_frame(2, 0, 2, 24, 1'b0);     // overscan only
    run_frame(3, 6, 3, 40, 1'b1);     // inputs changed and start during frame
    run_ignored(0, 4, 1);             // zero rows
    run_ignored(2, 0, 0);             // zero width
    for (int k = 0; k < 6; k++)
      run_frame(1 + int'($urandom_range(2)), int'($urandom_range(10)) + 1,
                int'($urandom_range(3)), 20 + int'($urandom_range(40)), 1'b0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule